// File: doc/BRIEF.md
# Interrupt Output Controller

This block merges three event sources (a watchdog timeout, an alarm match and a power-fail warning) into a small status register and a single interrupt pin. Every source event sets its own status flag whatever the configuration. A separate enable bit per source decides whether that event also activates the pin.

A control register chooses how the pin behaves. The polarity bit selects either an active-high push-pull output or an active-low open-drain output. For open-drain, the block drives the pin low with its output-enable set while active, and releases the output-enable while inactive. The mode bit selects either a pulse or a level. A pulse lasts a fixed number of timebase ticks; `PULSE_TICKS` is 200 for a 1 kHz tick. A level holds until software reads the flags or the control register.

Register access uses a one-bit address: 0 is the control register and 1 is the flag register. Read data is combinational while the read strobe is high. Any read of the flag register clears the flags.

Top module: `irq_out_top`

## Requirements
- R1: After reset the control register and all flags are 0, and the pin is inactive with the open-drain form (pinOut = 0, pinOe = 0).
- R2: The control register at address 0 keeps the bits it is written with at positions 7 (watchdog enable), 6 (alarm enable), 5 (power-fail enable), 2 (polarity, 1 = active high) and 1 (mode, 1 = pulse); bits 4, 3 and 0 always read 0.
- R3: A one-cycle event sets its flag on the next clock edge whether or not its enable is set. The flag register at address 1 holds watchdog in bit 0, alarm in bit 1 and power-fail in bit 2; bits 7..3 read 0.
- R4: A flag-register read returns the flags held before the read and clears them on that clock edge. An event that arrives in the same cycle as the read leaves its flag set.
- R5: The interrupt becomes active on the clock edge that samples an event whose enable bit is 1. An event whose enable is 0 never activates the pin.
- R6: When polarity is 1, pinOe = 1 and pinOut equals the active state. When polarity is 0, pinOut = 0 and pinOe equals the active state.
- R7: In pulse mode the interrupt stays active through PULSE_TICKS timebase ticks after the last enabled event and clears on the edge that samples the last of those ticks.
- R8: In pulse mode an enabled event that arrives while a pulse is running restarts the full tick count.
- R9: In level mode the interrupt stays active until a read of either register clears it on that read's edge. Timebase ticks have no effect in this mode, and an enabled event in the same cycle as the read keeps the interrupt active.
- R10: In pulse mode a register read does not end a running pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtWdog | input | 1 | Watchdog timeout event, one cycle |
| evtAlarm | input | 1 | Alarm match event, one cycle |
| evtPfail | input | 1 | Power-fail event, one cycle |
| tick | input | 1 | Timebase tick, one cycle per period |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 1 | 0 = control, 1 = flags |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data, 0 when no read |
| pinOut | output | 1 | Interrupt pin data |
| pinOe | output | 1 | Interrupt pin output-enable |

## Verification
The bench builds the block with PULSE_TICKS = 4. With that value the whole pulse, including the tick that ends it, takes only a few cycles to observe. This makes it cheap to sweep every source against all eight enable combinations, both polarities and both modes, which gives 96 configurations. Directed cases then cover a retriggered pulse, reads that coincide with events, and a control-register read that ends a level.

// File: rtl/irq_out_pkg.sv
package irq_out_pkg;
  localparam int SRC_N = 3;
  // Control register bit positions (software-visible layout).
  localparam int POS_POL   = 2;
  localparam int POS_PULSE = 1;
  localparam logic [7:0] CTL_MASK = 8'b1110_0110;

  // Access strobes decoded by the control module for the datapath.
  typedef struct packed {
    logic wrCtl;
    logic rdCtl;
    logic rdFlags;
  } accStrobe_t;
endpackage

// File: rtl/irq_out_ctrl.sv
module irq_out_ctrl
  import irq_out_pkg::*;
#(
  parameter int PULSE_TICKS = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic       regAddr,
  input  logic       tick,
  input  logic       raiseAny,
  input  logic       pulseMode,
  output accStrobe_t stb,
  output logic       active
);
  localparam int CNT_W = $clog2(PULSE_TICKS + 1);

  logic [CNT_W-1:0] cnt;

  always_comb begin
    stb.wrCtl   = regWrEn & ~regAddr;
    stb.rdCtl   = regRdEn & ~regAddr;
    stb.rdFlags = regRdEn &  regAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (raiseAny) begin
      active <= 1'b1;
      cnt    <= CNT_W'(PULSE_TICKS);
    end else if (active) begin
      if (pulseMode) begin
        if (tick) begin
          if (cnt <= CNT_W'(1)) begin
            active <= 1'b0;
            cnt    <= '0;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
      end else if (stb.rdCtl || stb.rdFlags) begin
        active <= 1'b0;
      end
    end
  end

  p_idle_stays_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !raiseAny) |=> !active);
  p_level_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (active && !pulseMode && !regRdEn) |=> active);
  p_pulse_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    (active && pulseMode && tick && cnt == CNT_W'(1) && !raiseAny) |=> !active);
  p_pulse_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    (active && pulseMode && !tick) |=> active);
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    int'(cnt) <= PULSE_TICKS);
endmodule

// File: rtl/irq_out_dp.sv
module irq_out_dp
  import irq_out_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SRC_N-1:0] evt,
  input  logic [7:0]       wrData,
  input  accStrobe_t       stb,
  input  logic             active,
  output logic [7:0]       rdData,
  output logic             raiseAny,
  output logic             pulseMode,
  output logic             pinOut,
  output logic             pinOe
);
  logic [7:0]       ctlReg;
  logic [SRC_N-1:0] flagQ;
  logic [SRC_N-1:0] enVec;
  logic             polHigh;

  always_ff @(posedge clk) begin
    if (!rstN)          ctlReg <= '0;
    else if (stb.wrCtl) ctlReg <= wrData & CTL_MASK;
  end

  // Source i is enabled by control bit 7-i.
  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    assign enVec[i] = ctlReg[7-i];

    always_ff @(posedge clk) begin
      if (!rstN)            flagQ[i] <= 1'b0;
      else if (stb.rdFlags) flagQ[i] <= evt[i];
      else                  flagQ[i] <= flagQ[i] | evt[i];
    end

    p_flag_set_r3: assert property (@(posedge clk) disable iff (!rstN)
      evt[i] |=> flagQ[i]);
    p_flag_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
      (stb.rdFlags && !evt[i]) |=> !flagQ[i]);
  end

  assign raiseAny  = |(evt & enVec);
  assign pulseMode = ctlReg[POS_PULSE];
  assign polHigh   = ctlReg[POS_POL];

  always_comb begin
    if (stb.rdCtl)        rdData = ctlReg;
    else if (stb.rdFlags) rdData = {{(8-SRC_N){1'b0}}, flagQ};
    else                  rdData = '0;
  end

  assign pinOut = polHigh & active;
  assign pinOe  = polHigh | active;

  p_ctl_layout_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctlReg & ~CTL_MASK) == 8'h00);
endmodule

// File: rtl/irq_out_top.sv
module irq_out_top
  import irq_out_pkg::*;
#(
  parameter int PULSE_TICKS = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       evtWdog,
  input  logic       evtAlarm,
  input  logic       evtPfail,
  input  logic       tick,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic       regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       pinOut,
  output logic       pinOe
);
  accStrobe_t stb;
  logic       active;
  logic       raiseAny;
  logic       pulseMode;

  irq_out_ctrl #(.PULSE_TICKS(PULSE_TICKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .tick(tick), .raiseAny(raiseAny),
    .pulseMode(pulseMode), .stb(stb), .active(active)
  );

  irq_out_dp u_dp (
    .clk(clk), .rstN(rstN), .evt({evtPfail, evtAlarm, evtWdog}),
    .wrData(regWrData), .stb(stb), .active(active), .rdData(regRdData),
    .raiseAny(raiseAny), .pulseMode(pulseMode), .pinOut(pinOut), .pinOe(pinOe)
  );
endmodule

// File: tb/irq_out_top_test.sv
module irq_out_top_test;
  localparam int PT = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN = 1'b0;
  logic       evtWdog = 0, evtAlarm = 0, evtPfail = 0, tick = 0;
  logic       regWrEn = 0, regRdEn = 0, regAddr = 0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       pinOut, pinOe;
  int nCmp = 0, nBad = 0;

  irq_out_top #(.PULSE_TICKS(PT)) uut (
    .clk(clk), .rstN(rstN), .evtWdog(evtWdog), .evtAlarm(evtAlarm),
    .evtPfail(evtPfail), .tick(tick), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pinChk(input string req, input bit act, input bit pol);
    chk(req, {6'b0, pinOut, pinOe}, {6'b0, pol & act, pol | act});
  endtask

  task automatic wrCtl(input logic [7:0] d);
    regWrEn = 1; regAddr = 0; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rdReg(input logic a, output logic [7:0] d);
    regRdEn = 1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 0;
  endtask

  task automatic fire(input int src);
    evtWdog = (src == 0); evtAlarm = (src == 1); evtPfail = (src == 2);
    @(negedge clk);
    evtWdog = 0; evtAlarm = 0; evtPfail = 0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick = 1; @(negedge clk); tick = 0;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  initial begin
    #(20 * 200000);
    nCmp++; nBad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    pinChk("R1 pin in reset", 0, 0);
    rstN = 1;
    @(negedge clk);
    pinChk("R1 pin after reset", 0, 0);
    rdReg(0, d); chk("R1 ctl reset", d, 8'h00);
    rdReg(1, d); chk("R1 flags reset", d, 8'h00);

    // Sweep: source x enables x polarity x mode.
    for (int src = 0; src < 3; src++)
      for (int e = 0; e < 8; e++)
        for (int pol = 0; pol < 2; pol++)
          for (int md = 0; md < 2; md++) begin
            logic [7:0] ctl;
            bit en;
            ctl = {e[0], e[1], e[2], 2'b00, pol[0], md[0], 1'b0};
            en = e[src];
            wrCtl(ctl);
            pinChk("R6 idle pin", 0, pol[0]);
            fire(src);
            pinChk("R5 pin after event", en, pol[0]);
            if (md == 1) begin
              ticks(PT - 1);
              pinChk("R7 pulse held", en, pol[0]);
              ticks(1);
              pinChk("R7 pulse ended", 0, pol[0]);
            end else begin
              ticks(PT + 2);
              pinChk("R9 level ignores ticks", en, pol[0]);
              if (src == 1) begin
                rdReg(0, d); chk("R2 ctl readback", d, ctl);
              end else begin
                rdReg(1, d); chk("R3 flag value", d, 8'(1 << src));
              end
              pinChk("R9 level cleared by read", 0, pol[0]);
            end
            rdReg(1, d);
            if (!(md == 0 && src != 1)) chk("R3 flag value", d, 8'(1 << src));
            rdReg(1, d); chk("R4 flags cleared", d, 8'h00);
          end

    // R2: reserved bits read 0.
    wrCtl(8'hFF);
    rdReg(0, d); chk("R2 reserved bits", d, 8'hE6);

    // R8: retrigger restarts the count.
    fire(0); ticks(2); fire(1); ticks(PT - 1);
    pinChk("R8 retrigger held", 1, 1);
    ticks(1);
    pinChk("R8 retrigger ended", 0, 1);
    rdReg(1, d); chk("R3 two flags", d, 8'h03);

    // R10: a read during a pulse does not end it.
    fire(2); rdReg(1, d); rdReg(0, d);
    pinChk("R10 pulse survives read", 1, 1);
    ticks(PT);
    pinChk("R10 pulse ends on ticks", 0, 1);

    // R4: event in the same cycle as a flag read.
    rdReg(1, d);
    evtPfail = 1; regRdEn = 1; regAddr = 1;
    #1 d = regRdData;
    @(negedge clk);
    evtPfail = 0; regRdEn = 0;
    chk("R4 read before set", d, 8'h00);
    rdReg(1, d); chk("R4 set wins over clear", d, 8'h04);

    // R9: level mode, event coincident with read keeps active, then ctl read clears.
    wrCtl(8'hE0);
    fire(0);
    pinChk("R6 open drain active", 1, 0);
    evtAlarm = 1; regRdEn = 1; regAddr = 1;
    @(negedge clk);
    evtAlarm = 0; regRdEn = 0;
    pinChk("R9 event with read keeps active", 1, 0);
    rdReg(0, d);
    pinChk("R9 ctl read clears level", 0, 0);
    fire(1); wrCtl(8'h00);
    pinChk("R5 disabled keeps state", 1, 0);
    rdReg(1, d);
    fire(2);
    pinChk("R5 disabled source no pin", 0, 0);
    rdReg(1, d); chk("R3 disabled source flags", d, 8'h04);

    summary();
    $finish;
  end
endmodule